// File: doc/BRIEF.md
# Low-Power Mode Clock Controller

This block turns the low-power control bits of a small microcontroller into clock enables inside the main-clock domain. It holds three bits: CPU halt, low-frequency oscillator off, and sub-main clock off. The CPU writes these bits from bits 4, 5 and 7 of its status register. From them the block drives a CPU-run enable, an auxiliary clock enable and a sub-main clock enable. The enables stand in for gated clocks.

The low-frequency oscillator arrives as an asynchronous toggle. It is synchronized and edge-detected into a one-cycle tick. The auxiliary enable follows this tick. The sub-main enable takes as its source either every main-clock cycle or the low-frequency tick, and then passes through a divider of 1, 2, 4 or 8.

An accepted interrupt, from any wake-up source such as a port edge, saves the current low-power bits and clears them, so the handler runs with every clock alive. A return from interrupt puts the saved bits back.

Top module: `lpm_clkctl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the low-power state is cleared and the divider counter is zeroed. After that edge `lpm_state_o` is 0, `cpu_run_en_o` is 1, and both clock enables run.
- R2: A write (`lpm_wr_i`) loads `lpm_wr_bits_i`. The encoding is [0] CPU halt, [1] oscillator off, [2] sub-main off. From the next cycle, `cpu_run_en_o` equals the inverse of the halt bit.
- R3: While the oscillator-off bit is set, `aclk_en_o` stays low.
- R4: While the oscillator-off bit is clear, each change of level on `lf_toggle_i` gives exactly one one-cycle pulse on `aclk_en_o`, two clock edges after the change.
- R5: While the sub-main-off bit is set, `smclk_en_o` stays low, and the divider counter is held at zero.
- R6: When `smclk_src_i` is 0 the divider source is every main-clock cycle. When it is 1 the source is the low-frequency tick.
- R7: When `smclk_div_i` = n, `smclk_en_o` gives one pulse per 2^n source pulses. Starting from a zeroed counter, the first pulse comes on the 2^n-th source pulse.
- R8: `irq_accept_i` saves the current low-power bits and clears them. From the next cycle all outputs run and `lpm_state_o` is 0. This takes priority over `reti_i` and `lpm_wr_i` in the same cycle.
- R9: `reti_i` restores the saved bits, and the stopped CPU or clocks stop again. In the same cycle it takes priority over `lpm_wr_i`.
- R10: `lpm_state_o` shows the low-power bits in force, with the same encoding as R2. A write made during a handler takes effect until the return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lf_toggle_i | input | 1 | Asynchronous low-frequency oscillator toggle |
| lpm_wr_i | input | 1 | Write strobe for the low-power bits |
| lpm_wr_bits_i | input | 3 | New low-power bits {sub-main off, osc off, CPU halt} |
| irq_accept_i | input | 1 | Interrupt entry pulse |
| reti_i | input | 1 | Interrupt return pulse |
| smclk_src_i | input | 1 | Sub-main source: 0 main clock, 1 low-frequency tick |
| smclk_div_i | input | DIV_W | Sub-main divide exponent |
| cpu_run_en_o | output | 1 | CPU instruction-execution enable |
| aclk_en_o | output | 1 | Auxiliary clock enable |
| smclk_en_o | output | 1 | Sub-main clock enable |
| lpm_state_o | output | 3 | Low-power bits in force |

## Verification
The bench sweeps all eight combinations of low-power bits, and for each combination it goes through interrupt entry and return. It counts enable pulses over fixed windows, so a design that ignored the override would show zero counts inside the handler, and a design that did not restore the bits would keep counting after the return. It sweeps every divide setting for both sources from a zeroed counter. A divider that did not clear while stopped, or that wrapped at the wrong count, shows a different pulse total. Same-cycle collisions of entry with return, and of return with a write, are driven directly, so a wrong priority leaves the wrong state.

// File: rtl/lpm_clkctl_pkg.sv
// Shared types for the low-power clock controller.
package lpm_clkctl_pkg;
    // Low-power bits in force; bit order matches the write encoding.
    typedef struct packed {
        logic sm_off;   // [2] stop sub-main clock
        logic osc_off;  // [1] stop low-frequency oscillator
        logic halt;     // [0] stop CPU execution
    } lpm_bits_t;

    localparam int LPM_W = 3;
endpackage

// File: rtl/lpm_bit_reg.sv
// Holds the low-power bits and the copy saved on interrupt entry.
// Assumes irq_accept and reti are single-cycle pulses in the clk domain;
// one level of save (no nesting). Priority: accept > return > write.
module lpm_bit_reg
    import lpm_clkctl_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_i,
    input  lpm_bits_t wr_bits_i,
    input  logic      accept_i,
    input  logic      ret_i,
    output lpm_bits_t active_o
);
    lpm_bits_t active_q;
    lpm_bits_t saved_q;

    // Update the live and saved bits by priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= '0;
            saved_q  <= '0;
        end else if (accept_i) begin
            saved_q  <= active_q;
            active_q <= '0;
        end else if (ret_i) begin
            active_q <= saved_q;
        end else if (wr_i) begin
            active_q <= wr_bits_i;
        end
    end

    assign active_o = active_q;
endmodule

// File: rtl/lf_tick_sync.sv
// Synchronizes an asynchronous toggle and turns each level change into
// a one-cycle tick. Assumes the toggle changes no faster than once per clk.
module lf_tick_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic toggle_i,
    output logic tick_o
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    // Shift chain plus one history flop for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], toggle_i};
            prev_q <= sync_q[SYNC_STAGES-1];
        end
    end

    assign tick_o = sync_q[SYNC_STAGES-1] ^ prev_q;
endmodule

// File: rtl/clk_en_div.sv
// Selects a source pulse (every cycle or a tick) and divides it by 2^sel.
// Counter is cleared while stopped, so a restart begins a fresh period.
module clk_en_div #(
    parameter int DIV_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             src_tick_i,
    input  logic             tick_i,
    input  logic [DIV_W-1:0] div_sel_i,
    input  logic             stop_i,
    output logic             en_o
);
    localparam int CNT_W = (1 << DIV_W) - 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last;
    logic             src_pulse;
    logic             wrap;

    // Terminal count for the selected ratio and source choice.
    always_comb begin
        last      = CNT_W'((1 << div_sel_i) - 1);
        src_pulse = src_tick_i ? tick_i : 1'b1;
        wrap      = (cnt_q >= last);
        en_o      = src_pulse && !stop_i && wrap;
    end

    // Count source pulses; hold at zero when stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || stop_i) begin
            cnt_q <= '0;
        end else if (src_pulse) begin
            cnt_q <= wrap ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/lpm_clkctl.sv
// Low-power mode clock controller top. Converts the low-power bits into
// CPU-run, auxiliary and sub-main clock enables in the main-clock domain.
// Assumes clock enables replace gated clocks downstream.
module lpm_clkctl #(
    parameter int DIV_W       = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lf_toggle_i,
    input  logic             lpm_wr_i,
    input  logic [2:0]       lpm_wr_bits_i,
    input  logic             irq_accept_i,
    input  logic             reti_i,
    input  logic             smclk_src_i,
    input  logic [DIV_W-1:0] smclk_div_i,
    output logic             cpu_run_en_o,
    output logic             aclk_en_o,
    output logic             smclk_en_o,
    output logic [2:0]       lpm_state_o
);
    import lpm_clkctl_pkg::*;

    lpm_bits_t active;
    logic      lf_tick;

    lpm_bit_reg u_bits (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (lpm_wr_i),
        .wr_bits_i (lpm_bits_t'(lpm_wr_bits_i)),
        .accept_i  (irq_accept_i),
        .ret_i     (reti_i),
        .active_o  (active)
    );

    lf_tick_sync #(.SYNC_STAGES(SYNC_STAGES)) u_lf (
        .clk      (clk),
        .rst_n    (rst_n),
        .toggle_i (lf_toggle_i),
        .tick_o   (lf_tick)
    );

    clk_en_div #(.DIV_W(DIV_W)) u_smdiv (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_tick_i (smclk_src_i),
        .tick_i     (lf_tick),
        .div_sel_i  (smclk_div_i),
        .stop_i     (active.sm_off),
        .en_o       (smclk_en_o)
    );

    // Gate the CPU and auxiliary enables with the bits in force.
    always_comb begin
        cpu_run_en_o = !active.halt;
        aclk_en_o    = lf_tick && !active.osc_off;
        lpm_state_o  = active;
    end
endmodule

// File: rtl/lpm_clkctl_chk.sv
// Assertion checker for lpm_clkctl, attached by bind.
module lpm_clkctl_chk #(
    parameter int DIV_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             lpm_wr_i,
    input logic [2:0]       lpm_wr_bits_i,
    input logic             irq_accept_i,
    input logic             reti_i,
    input logic             smclk_src_i,
    input logic [DIV_W-1:0] smclk_div_i,
    input logic             cpu_run_en_o,
    input logic             aclk_en_o,
    input logic             smclk_en_o,
    input logic [2:0]       lpm_state_o
);
    // R1: the first cycle after reset has everything running.
    p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (lpm_state_o == 3'b000) && cpu_run_en_o);

    // R2: a plain write with the halt bit stops the CPU next cycle.
    p_cpu_halt_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (lpm_wr_i && !irq_accept_i && !reti_i && lpm_wr_bits_i[0]) |=> !cpu_run_en_o);

    // R3: no auxiliary pulses while the oscillator is off.
    p_aclk_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        lpm_state_o[1] |-> !aclk_en_o);

    // R5: no sub-main pulses while that clock is off.
    p_smclk_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        lpm_state_o[2] |-> !smclk_en_o);

    // R6: main source with ratio one pulses on every cycle.
    p_main_every_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!smclk_src_i && smclk_div_i == '0 && !lpm_state_o[2]) |-> smclk_en_o);

    // R8: interrupt entry wakes everything on the next cycle.
    p_wake_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_accept_i |=> (lpm_state_o == 3'b000) && cpu_run_en_o);
endmodule

bind lpm_clkctl lpm_clkctl_chk #(.DIV_W(DIV_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .lpm_wr_i      (lpm_wr_i),
    .lpm_wr_bits_i (lpm_wr_bits_i),
    .irq_accept_i  (irq_accept_i),
    .reti_i        (reti_i),
    .smclk_src_i   (smclk_src_i),
    .smclk_div_i   (smclk_div_i),
    .cpu_run_en_o  (cpu_run_en_o),
    .aclk_en_o     (aclk_en_o),
    .smclk_en_o    (smclk_en_o),
    .lpm_state_o   (lpm_state_o)
);

// File: tb/lpm_clkctl_tb_top.sv
// Self-checking bench: window pulse counts over swept configurations.
module lpm_clkctl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WIN        = 60;  // toggling part of a window
    localparam int TAIL       = 4;   // quiet cycles to flush ticks

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       lf_toggle = 1'b0;
    logic       lpm_wr = 1'b0;
    logic [2:0] lpm_wr_bits = 3'b000;
    logic       irq_accept = 1'b0;
    logic       reti = 1'b0;
    logic       smclk_src = 1'b0;
    logic [1:0] smclk_div = 2'd0;
    logic       cpu_run_en, aclk_en, smclk_en;
    logic [2:0] lpm_state;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lpm_clkctl dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .lf_toggle_i   (lf_toggle),
        .lpm_wr_i      (lpm_wr),
        .lpm_wr_bits_i (lpm_wr_bits),
        .irq_accept_i  (irq_accept),
        .reti_i        (reti),
        .smclk_src_i   (smclk_src),
        .smclk_div_i   (smclk_div),
        .cpu_run_en_o  (cpu_run_en),
        .aclk_en_o     (aclk_en),
        .smclk_en_o    (smclk_en),
        .lpm_state_o   (lpm_state)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One-cycle control pulse; state is updated when this returns.
    task automatic ctl(input bit wr, input logic [2:0] bits, input bit acc, input bit ret);
        @(negedge clk);
        lpm_wr = wr; lpm_wr_bits = bits; irq_accept = acc; reti = ret;
        @(negedge clk);
        lpm_wr = 1'b0; irq_accept = 1'b0; reti = 1'b0;
    endtask

    // Count enables over WIN+TAIL cycles, toggling the oscillator every per cycles.
    task automatic run_win(input int per, output int n_cpu, output int n_acl, output int n_sm);
        n_cpu = 0; n_acl = 0; n_sm = 0;
        for (int i = 0; i < WIN + TAIL; i++) begin
            @(negedge clk);
            n_cpu += int'(cpu_run_en);
            n_acl += int'(aclk_en);
            n_sm  += int'(smclk_en);
            if (per != 0 && i < WIN && (i % per) == 0) lf_toggle = ~lf_toggle;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int nc, na, ns, ticks;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 state", int'(lpm_state), 0);
        chk("R1 cpu", int'(cpu_run_en), 1);
        chk("R1 smclk", int'(smclk_en), 1);

        // R6/R7 main source, every ratio
        for (int d = 0; d < 4; d++) begin
            smclk_div = 2'(d);
            run_win(0, nc, na, ns);
            chk("R7 main div", ns, (WIN + TAIL) >> d);
            chk("R6 main src", nc, WIN + TAIL);
        end

        // R4/R6 low-frequency source, ratio one, several toggle periods
        smclk_src = 1'b1; smclk_div = 2'd0;
        for (int p = 3; p <= 9; p += 2) begin
            ticks = (WIN + p - 1) / p;
            run_win(p, nc, na, ns);
            chk("R4 aclk ticks", na, ticks);
            chk("R6 lf src", ns, ticks);
        end

        // R5/R7 low-frequency source, every ratio from a cleared counter
        for (int d = 0; d < 4; d++) begin
            smclk_div = 2'(d);
            ctl(1'b1, 3'b100, 1'b0, 1'b0);
            ctl(1'b1, 3'b000, 1'b0, 1'b0);
            run_win(3, nc, na, ns);
            chk("R7 lf div", ns, 20 >> d);
            chk("R4 aclk", na, 20);
        end

        // Exhaustive bits with entry and return. Main source, ratio 2.
        smclk_src = 1'b0; smclk_div = 2'd1;
        for (int c = 0; c < 8; c++) begin
            ctl(1'b1, 3'(c), 1'b0, 1'b0);
            chk("R10 state", int'(lpm_state), c);
            run_win(5, nc, na, ns);
            chk("R2 cpu", nc, c[0] ? 0 : 64);
            chk("R3 aclk", na, c[1] ? 0 : 12);
            chk("R5 smclk", ns, c[2] ? 0 : 32);
            // interrupt entry: wake within one cycle
            @(negedge clk); irq_accept = 1'b1;
            @(negedge clk); irq_accept = 1'b0;
            chk("R8 wake cpu", int'(cpu_run_en), 1);
            chk("R8 state", int'(lpm_state), 0);
            run_win(5, nc, na, ns);
            chk("R8 cpu run", nc, 64);
            chk("R8 aclk run", na, 12);
            chk("R8 smclk run", ns, 32);
            ctl(1'b0, 3'b000, 1'b0, 1'b1);
            chk("R9 restore", int'(lpm_state), c);
            run_win(5, nc, na, ns);
            chk("R9 cpu", nc, c[0] ? 0 : 64);
            chk("R9 aclk", na, c[1] ? 0 : 12);
            chk("R9 smclk", ns, c[2] ? 0 : 32);
            ctl(1'b1, 3'b000, 1'b0, 1'b0);
        end

        // R8 entry beats return in the same cycle
        ctl(1'b1, 3'b111, 1'b0, 1'b0);
        ctl(1'b1, 3'b010, 1'b1, 1'b1);
        chk("R8 priority", int'(lpm_state), 0);
        ctl(1'b0, 3'b000, 1'b0, 1'b1);
        chk("R9 after prio", int'(lpm_state), 7);

        // R10 write inside handler, then R9 return beats write
        ctl(1'b1, 3'b001, 1'b0, 1'b0);
        ctl(1'b0, 3'b000, 1'b1, 1'b0);
        ctl(1'b1, 3'b110, 1'b0, 1'b0);
        chk("R10 isr write", int'(lpm_state), 6);
        ctl(1'b1, 3'b100, 1'b0, 1'b1);
        chk("R9 over write", int'(lpm_state), 1);
        chk("R2 halted", int'(cpu_run_en), 0);

        // R1 reset from deep low-power
        ctl(1'b1, 3'b111, 1'b0, 1'b0);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        chk("R1 re-reset state", int'(lpm_state), 0);
        chk("R1 re-reset cpu", int'(cpu_run_en), 1);
        smclk_div = 2'd2;
        run_win(0, nc, na, ns);
        chk("R1 counter zero", ns, 16);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule